// File: doc/BRIEF.md
# Program Memory Read-Protection Controller

This block owns a small one-time-programmable program store and stands between it and an external programming port. A programmer writes words, reads them back one cycle after each read strobe, and can query a separate security status location that sits outside the normal address space. Once the programmer signals that verification has completed, a lock request turns on read protection. From then on every external read of the array returns zero, while the internal instruction-fetch port keeps seeing the real contents.

Programming follows one-time cell rules: a write can only clear bits, never set them. An on-chip blank-check sweep walks every address through the same protected read path and reports whether every word still holds the erased value. A protected part therefore always fails that sweep, and it fails any external compare against the intended image. Protection is one-way. Only the block reset, which stands for a full re-initialisation of the non-volatile model, clears it.

Top module: `pmem_guard`

## Requirements
- R1: While `rst_n` is low and right after it is released, the part is unprotected, every array word reads 0xFF, `pgm_rvalid` is 0, `blank_busy` is 0 and `blank_pass` is 0.
- R2: A `pgm_wr` with `pgm_sec_sel` low replaces the addressed word with its bitwise AND with `pgm_wdata`. Bits can only go from 1 to 0. A `pgm_wr` with `pgm_sec_sel` high leaves the array unchanged.
- R3: A `pgm_rd` accepted while no blank sweep is running raises `pgm_rvalid` for exactly the next cycle. `pgm_rdata` then holds the addressed word, as it was in the strobe cycle, when the part is unprotected. With no accepted strobe, `pgm_rvalid` is 0.
- R4: A read with `pgm_sec_sel` high returns the security status byte: 0x00 when unprotected and 0xFF when protected, as sampled in the strobe cycle.
- R5: `pgm_lock` turns protection on only if a `pgm_verified` pulse has been seen since reset. A lock request made before that has no effect, and it is not remembered.
- R6: Once protection is on, it stays on whatever the programming port does. Only `rst_n` clears it.
- R7: While protected, every array read on the programming port returns 0x00.
- R8: `cpu_rdata` always shows the true array word at `cpu_addr` in the same cycle, whether or not the part is protected.
- R9: A `blank_go` pulse while idle raises `blank_busy` for exactly 2^AW cycles, reading one address per cycle through the protected path. When `blank_busy` falls, `blank_pass` is 1 only if every word read equalled 0xFF. A protected part therefore fails the sweep even when it is erased. `blank_pass` is cleared when a sweep starts.
- R10: While `blank_busy` is high, `pgm_rd` strobes are ignored (no `pgm_rvalid`) and a further `blank_go` does not restart the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also re-initialises the array and protection |
| cpu_addr | input | AW | Instruction-fetch address |
| cpu_rdata | output | DW | True array word at `cpu_addr` (combinational) |
| pgm_addr | input | AW | Programming-port word address |
| pgm_sec_sel | input | 1 | Selects the security status location instead of the array |
| pgm_rd | input | 1 | Read strobe |
| pgm_wr | input | 1 | Program strobe |
| pgm_wdata | input | DW | Program data (ANDed into the cell) |
| pgm_verified | input | 1 | Pulse: the image has been programmed and verified |
| pgm_lock | input | 1 | Request to turn on read protection |
| pgm_rdata | output | DW | Registered read data |
| pgm_rvalid | output | 1 | High the cycle after an accepted read |
| blank_go | input | 1 | Starts a blank-check sweep |
| blank_busy | output | 1 | Sweep in progress |
| blank_pass | output | 1 | Result of the last completed sweep |

## Verification
The properties assume that the programming-port strobes are clean, single-cycle-sampled levels, and that `pgm_sec_sel` and `pgm_addr` are meaningful only in the cycle of a strobe. They also assume that a read result depends on the protection state in the strobe cycle, not the result cycle. The stimulus drives every input on the falling edge, holds each strobe for exactly one cycle, and never changes the protection state in the same cycle as a read it later compares. Lock and verify pulses are issued between reads, so each expected value follows from the requirement alone.

// File: rtl/pmem_guard_pkg.sv
package pmem_guard_pkg;
  localparam logic [7:0] ERASED_BYTE  = 8'hFF;
  localparam logic [7:0] SEC_ON_BYTE  = 8'hFF;
  localparam logic [7:0] SEC_OFF_BYTE = 8'h00;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/pmem_array.sv
module pmem_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] fetch_addr,
  output logic [DW-1:0] fetch_data,
  input  logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cell_q [DEPTH];
  logic [DW-1:0] cell_d [DEPTH];

  // One-time cells: a program pulse can only clear bits.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && (wr_addr == AW'(i))) cell_d[i] = cell_q[i] & wr_data;
      else                              cell_d[i] = cell_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= {DW{1'b1}};
    end else if (wr_en) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= cell_d[i];
    end
  end

  assign fetch_data = cell_q[fetch_addr];
  assign prog_data  = cell_q[prog_addr];
endmodule

// File: rtl/pmem_sec_state.sv
module pmem_sec_state (
  input  logic clk,
  input  logic rst_n,
  input  logic verify_done,
  input  logic lock_req,
  output logic verified,
  output logic secured
);
  logic verified_d, secured_d;

  always_comb begin
    verified_d = verified | verify_done;
    // The lock only counts once an earlier verify pulse has been registered.
    secured_d  = secured | (lock_req & verified);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verified <= 1'b0;
      secured  <= 1'b0;
    end else begin
      verified <= verified_d;
      secured  <= secured_d;
    end
  end
endmodule

// File: rtl/pmem_blank_scan.sv
module pmem_blank_scan
  import pmem_guard_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] word,
  output logic [AW-1:0] addr,
  output logic          busy,
  output logic          pass
);
  localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};
  localparam logic [DW-1:0] ERASED    = DW'(ERASED_BYTE) | {DW{1'b1}};

  scan_state_e   st_q, st_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          acc_q, acc_d;
  logic          pass_q, pass_d;
  logic          word_ok;

  assign word_ok = (word == ERASED);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    acc_d  = acc_q;
    pass_d = pass_q;
    unique case (st_q)
      SCAN_IDLE: begin
        if (go) begin
          st_d   = SCAN_RUN;
          idx_d  = '0;
          acc_d  = 1'b1;
          pass_d = 1'b0;
        end
      end
      SCAN_RUN: begin
        acc_d = acc_q & word_ok;
        if (idx_q == LAST_ADDR) begin
          st_d   = SCAN_IDLE;
          pass_d = acc_q & word_ok;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SCAN_IDLE;
      idx_q  <= '0;
      acc_q  <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      pass_q <= pass_d;
    end
  end

  assign addr = idx_q;
  assign busy = (st_q == SCAN_RUN);
  assign pass = pass_q;
endmodule

// File: rtl/pmem_guard.sv
module pmem_guard
  import pmem_guard_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  output logic [DW-1:0] cpu_rdata,
  input  logic [AW-1:0] pgm_addr,
  input  logic          pgm_sec_sel,
  input  logic          pgm_rd,
  input  logic          pgm_wr,
  input  logic [DW-1:0] pgm_wdata,
  input  logic          pgm_verified,
  input  logic          pgm_lock,
  output logic [DW-1:0] pgm_rdata,
  output logic          pgm_rvalid,
  input  logic          blank_go,
  output logic          blank_busy,
  output logic          blank_pass
);
  logic          verified, secured;
  logic [AW-1:0] scan_addr, port_addr;
  logic [DW-1:0] port_word, masked_word, status_word;
  logic          rd_fire, arr_wr;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rvalid_q, rvalid_d;

  assign arr_wr = pgm_wr & ~pgm_sec_sel;

  pmem_array #(.AW(AW), .DW(DW)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (arr_wr),
    .wr_addr    (pgm_addr),
    .wr_data    (pgm_wdata),
    .fetch_addr (cpu_addr),
    .fetch_data (cpu_rdata),
    .prog_addr  (port_addr),
    .prog_data  (port_word)
  );

  pmem_sec_state u_sec (
    .clk         (clk),
    .rst_n       (rst_n),
    .verify_done (pgm_verified),
    .lock_req    (pgm_lock),
    .verified    (verified),
    .secured     (secured)
  );

  pmem_blank_scan #(.AW(AW), .DW(DW)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (blank_go),
    .word  (masked_word),
    .addr  (scan_addr),
    .busy  (blank_busy),
    .pass  (blank_pass)
  );

  // The sweep borrows the programming read port while it runs.
  assign port_addr   = blank_busy ? scan_addr : pgm_addr;
  assign masked_word = secured ? '0 : port_word;
  assign status_word = secured ? DW'(SEC_ON_BYTE) : DW'(SEC_OFF_BYTE);

  always_comb begin
    rd_fire  = pgm_rd & ~blank_busy;
    rvalid_d = rd_fire;
    rdata_d  = pgm_sec_sel ? status_word : masked_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      if (rd_fire) rdata_q <= rdata_d;
    end
  end

  assign pgm_rdata  = rdata_q;
  assign pgm_rvalid = rvalid_q;
endmodule

// File: rtl/pmem_guard_chk.sv
module pmem_guard_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pgm_rd,
  input logic          pgm_sec_sel,
  input logic          pgm_lock,
  input logic [DW-1:0] pgm_rdata,
  input logic          pgm_rvalid,
  input logic          blank_busy,
  input logic          blank_pass,
  input logic          verified,
  input logic          secured
);
  AST_SEC_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    secured |=> secured); // R6

  AST_LOCK_AFTER_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(secured) |-> $past(pgm_lock && verified)); // R5

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_rd && !blank_busy) |=> pgm_rvalid); // R3

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_rd |=> !pgm_rvalid); // R3

  AST_BUSY_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    blank_busy |=> !pgm_rvalid); // R10

  AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_rd && !blank_busy && !pgm_sec_sel && secured) |=> (pgm_rdata == '0)); // R7

  AST_STATUS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_rd && !blank_busy && pgm_sec_sel) |=> (pgm_rdata == {DW{$past(secured)}})); // R4

  AST_SECURED_FAILS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_busy && secured) |=> (!blank_busy -> !blank_pass)); // R9
endmodule

bind pmem_guard pmem_guard_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pgm_rd      (pgm_rd),
  .pgm_sec_sel (pgm_sec_sel),
  .pgm_lock    (pgm_lock),
  .pgm_rdata   (pgm_rdata),
  .pgm_rvalid  (pgm_rvalid),
  .blank_busy  (blank_busy),
  .blank_pass  (blank_pass),
  .verified    (verified),
  .secured     (secured)
);

// File: tb/tb_pmem_guard.sv
module tb_pmem_guard;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] cpu_addr, pgm_addr;
  logic [DW-1:0] cpu_rdata, pgm_wdata, pgm_rdata;
  logic          pgm_sec_sel, pgm_rd, pgm_wr, pgm_verified, pgm_lock;
  logic          pgm_rvalid, blank_go, blank_busy, blank_pass;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [DEPTH];

  always #10 clk = ~clk;

  pmem_guard #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
    .pgm_addr(pgm_addr), .pgm_sec_sel(pgm_sec_sel), .pgm_rd(pgm_rd),
    .pgm_wr(pgm_wr), .pgm_wdata(pgm_wdata), .pgm_verified(pgm_verified),
    .pgm_lock(pgm_lock), .pgm_rdata(pgm_rdata), .pgm_rvalid(pgm_rvalid),
    .blank_go(blank_go), .blank_busy(blank_busy), .blank_pass(blank_pass)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat_a(input int a);
    return DW'((a * 37 + 11) & 8'hFF);
  endfunction

  function automatic logic [DW-1:0] pat_b(input int a);
    return DW'(((a * 13) ^ 8'hC3) & 8'hFF);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
  endtask

  task automatic pulse_verified();
    pgm_verified = 1'b1; @(negedge clk); pgm_verified = 1'b0;
  endtask

  task automatic pulse_lock();
    pgm_lock = 1'b1; @(negedge clk); pgm_lock = 1'b0;
  endtask

  task automatic write_word(input int a, input logic [DW-1:0] d, input logic sel);
    pgm_addr = AW'(a); pgm_wdata = d; pgm_sec_sel = sel; pgm_wr = 1'b1;
    @(negedge clk);
    pgm_wr = 1'b0; pgm_sec_sel = 1'b0;
    if (!sel) model[a] = model[a] & d;
  endtask

  task automatic read_word(input int a, input logic sel, output logic [DW-1:0] d, output logic v);
    pgm_addr = AW'(a); pgm_sec_sel = sel; pgm_rd = 1'b1;
    @(negedge clk);
    pgm_rd = 1'b0; pgm_sec_sel = 1'b0;
    d = pgm_rdata; v = pgm_rvalid;
  endtask

  task automatic run_blank(input logic exp_pass, input string req);
    int n = 0;
    blank_go = 1'b1; @(negedge clk); blank_go = 1'b0;
    chk(req, blank_busy, 1'b1);
    chk(req, blank_pass, 1'b0);
    n = 1;
    while (blank_busy && n < 4 * DEPTH) begin
      @(negedge clk); n++;
    end
    chk("R9 sweep length", n, DEPTH + 1);
    chk(req, blank_pass, exp_pass);
  endtask

  task automatic sweep_reads(input logic prot, input string req);
    logic [DW-1:0] d; logic v;
    for (int a = 0; a < DEPTH; a++) begin
      read_word(a, 1'b0, d, v);
      chk("R3 rvalid", v, 1'b1);
      chk(req, d, prot ? 8'h00 : model[a]);
      cpu_addr = AW'(a); #1;
      chk("R8 fetch", cpu_rdata, model[a]);
    end
  endtask

  initial begin : watchdog
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d; logic v;
    cpu_addr = '0; pgm_addr = '0; pgm_wdata = '0; pgm_sec_sel = 1'b0;
    pgm_rd = 1'b0; pgm_wr = 1'b0; pgm_verified = 1'b0; pgm_lock = 1'b0; blank_go = 1'b0;
    rst_n = 1'b0;
    #5;
    chk("R1 rvalid in reset", pgm_rvalid, 1'b0);
    chk("R1 busy in reset", blank_busy, 1'b0);
    chk("R1 pass in reset", blank_pass, 1'b0);
    do_reset();
    chk("R1 rvalid", pgm_rvalid, 1'b0);
    chk("R1 busy", blank_busy, 1'b0);
    chk("R1 pass", blank_pass, 1'b0);
    @(negedge clk);
    chk("R3 idle no rvalid", pgm_rvalid, 1'b0);
    read_word(0, 1'b1, d, v);
    chk("R4 status unprotected", d, 8'h00);
    sweep_reads(1'b0, "R1 erased read");
    run_blank(1'b1, "R9 erased passes");

    // Lock before any verify pulse: ignored and not remembered.
    pulse_lock();
    @(negedge clk);
    read_word(0, 1'b1, d, v);
    chk("R5 early lock ignored", d, 8'h00);

    for (int a = 0; a < DEPTH; a++) write_word(a, pat_a(a), 1'b0);
    sweep_reads(1'b0, "R2 programmed read");
    write_word(5, 8'h00, 1'b1);
    read_word(5, 1'b0, d, v);
    chk("R2 status write leaves array", d, pat_a(5));
    for (int a = 0; a < DEPTH; a += 2) write_word(a, pat_b(a), 1'b0);
    write_word(7, 8'hFF, 1'b0);
    sweep_reads(1'b0, "R2 and-only program");

    // Reads and restarts during a sweep are dropped.
    blank_go = 1'b1; @(negedge clk); blank_go = 1'b0;
    repeat (3) @(negedge clk);
    read_word(3, 1'b0, d, v);
    chk("R10 read during sweep", v, 1'b0);
    blank_go = 1'b1; @(negedge clk); blank_go = 1'b0;
    chk("R10 go during sweep", blank_busy, 1'b1);
    while (blank_busy) @(negedge clk);
    chk("R9 programmed fails", blank_pass, 1'b0);
    read_word(3, 1'b0, d, v);
    chk("R10 read after sweep", v, 1'b1);

    pulse_verified();
    read_word(0, 1'b1, d, v);
    chk("R5 verify alone", d, 8'h00);
    pulse_lock();
    read_word(0, 1'b1, d, v);
    chk("R4 status protected", d, 8'hFF);
    sweep_reads(1'b1, "R7 protected read");
    run_blank(1'b0, "R9 protected fails");

    pulse_verified(); pulse_lock();
    write_word(9, 8'h00, 1'b1);
    write_word(0, 8'hFF, 1'b1);
    repeat (4) @(negedge clk);
    read_word(0, 1'b1, d, v);
    chk("R6 still protected", d, 8'hFF);

    do_reset();
    read_word(0, 1'b1, d, v);
    chk("R6 reset clears", d, 8'h00);
    read_word(9, 1'b0, d, v);
    chk("R1 erased after reset", d, 8'hFF);
    pulse_lock();
    read_word(0, 1'b1, d, v);
    chk("R5 lock after reset needs verify", d, 8'h00);
    pulse_verified(); pulse_lock();
    run_blank(1'b0, "R9 erased but protected fails");
    cpu_addr = AW'(9); #1;
    chk("R8 fetch erased protected", cpu_rdata, 8'hFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule